// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block adds or subtracts two 64-bit words treated as a set of packed integer lanes. A two-bit select splits the 64-bit datapath at run time into eight byte lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Carries and borrows never pass from one lane into the next, so every lane behaves as an independent adder of its own width.

For the two narrow lane sizes, a saturate enable replaces modular wraparound with clamping. A signed select picks the range the result is clamped to. Saturated packed arithmetic of this kind suits audio and pixel kernels, where an overflow should stop at full scale and never wrap to the opposite extreme. The result is registered and comes out with a valid flag one cycle after the input strobe.

Top module: `simd_sat_adder`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` equals the value `in_valid` had on the previous rising clock edge, and `result` holds the outcome of the operands sampled on that edge.
- R3: When `in_valid` is low at a rising edge, `result` keeps its previous value.
- R4: `lane_sel` 0, 1, 2 and 3 select lane widths of 8, 16, 32 and 64 bits. Lane k occupies bits k*w up to k*w+w-1, and no carry or borrow crosses from lane k into lane k+1.
- R5: With `sat_en` low, each lane computes a+b (`sub`=0) or a-b (`sub`=1) modulo 2^w.
- R6: With `sat_en` high, `signed_mode` low and a lane width of 8 or 16, an unsigned sum above 2^w-1 gives 2^w-1, and a difference below 0 gives 0.
- R7: With `sat_en` high, `signed_mode` high and a lane width of 8 or 16, each lane result is clamped to the range -2^(w-1) through 2^(w-1)-1.
- R8: For lane widths of 32 and 64, `sat_en` and `signed_mode` have no effect and every lane wraps modulo 2^w.
- R9: With `sat_en` low, `signed_mode` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| a | input | 64 | First operand (minuend when subtracting) |
| b | input | 64 | Second operand (subtrahend when subtracting) |
| lane_sel | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| sub | input | 1 | 0 adds, 1 subtracts b from a |
| sat_en | input | 1 | 1 saturates 8- and 16-bit lanes |
| signed_mode | input | 1 | 1 clamps to the signed range, 0 to the unsigned range |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Packed result |

## Verification
Operands near the lane extremes, such as 0x7F, 0x80, 0xFF and 0x00 repeated in every lane, are applied under all 32 mode combinations. These values separate clamp-to-maximum from clamp-to-minimum and signed from unsigned bounds. They also show whether a lane boundary leaks a carry. Uniform random operands then exercise carry propagation inside wide lanes. An all-ones plus one pattern with 8-bit lanes isolates the boundary blocking. A cycle with `in_valid` low shows that the register holds its value.

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       lane_sel,
  input  logic             sub,
  input  logic             sat_en,
  input  logic             signed_mode,
  output logic             out_valid,
  output logic [WIDTH-1:0] result
);
  localparam int NB = WIDTH / 8;

  logic [WIDTH-1:0] bx;
  logic [WIDTH-1:0] res_d;
  logic [NB-1:0]    co;
  logic [NB-1:0]    ovs;
  logic [NB-1:0]    amsb;
  logic             sat_ok;

  assign bx     = sub ? ~b : b;
  assign sat_ok = sat_en && !lane_sel[1];

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam int T16 = i | 1;
    logic       start;
    logic       cin;
    logic [8:0] s;
    logic       tov, tam, tco, hi, lo, top;

    always_comb begin
      case (lane_sel)
        2'd0:    start = 1'b1;
        2'd1:    start = (i % 2) == 0;
        2'd2:    start = (i % 4) == 0;
        default: start = (i == 0);
      endcase
    end

    if (i == 0) begin : g_first
      assign cin = sub;
    end else begin : g_rest
      assign cin = start ? sub : co[i-1];
    end

    assign s       = {1'b0, a[8*i +: 8]} + {1'b0, bx[8*i +: 8]} + {8'd0, cin};
    assign co[i]   = s[8];
    assign amsb[i] = a[8*i+7];
    assign ovs[i]  = (a[8*i+7] == bx[8*i+7]) && (s[7] != a[8*i+7]);

    assign top = (lane_sel == 2'd0) || ((i % 2) == 1);
    assign tov = (lane_sel == 2'd0) ? ovs[i]  : ovs[T16];
    assign tam = (lane_sel == 2'd0) ? amsb[i] : amsb[T16];
    assign tco = (lane_sel == 2'd0) ? co[i]   : co[T16];

    assign hi = sat_ok && (signed_mode ? (tov && !tam) : (!sub && tco));
    assign lo = sat_ok && (signed_mode ? (tov && tam)  : (sub && !tco));

    assign res_d[8*i +: 8] = hi ? ((signed_mode && top) ? 8'h7F : 8'hFF) :
                             lo ? ((signed_mode && top) ? 8'h80 : 8'h00) :
                                  s[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_d;
    end
  end
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [1:0]       lane_sel,
  input logic             sub,
  input logic             sat_en,
  input logic             signed_mode,
  input logic             out_valid,
  input logic [WIDTH-1:0] result
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  p_lane_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'd0 && !sat_en && !sub) |=>
      result[15:8] == 8'($past(a[15:8]) + $past(b[15:8])));

  p_wide_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'd3 && !sub) |=> result == $past(a) + $past(b));

  p_usat_add_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'd0 && sat_en && !signed_mode && !sub) |=>
      result[7:0] >= $past(a[7:0]));

  p_usat_sub_ceil_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'd0 && sat_en && !signed_mode && sub) |=>
      result[7:0] <= $past(a[7:0]));
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_simd_sat_adder.sv
`timescale 1ns/1ps
module sim_simd_sat_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic [1:0]  lane_sel = '0;
  logic        sub = 1'b0, sat_en = 1'b0, signed_mode = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  simd_sat_adder u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .lane_sel(lane_sel), .sub(sub), .sat_en(sat_en), .signed_mode(signed_mode),
    .out_valid(out_valid), .result(result));

  function automatic logic [63:0] model(input logic [63:0] x, y, input logic [1:0] ls,
                                        input logic s, st, sg);
    int w = 8 << ls;
    logic [63:0] r = '0;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    for (int k = 0; k < 64 / w; k++) begin
      logic [63:0] xa = (x >> (k * w)) & mask;
      logic [63:0] ya = (y >> (k * w)) & mask;
      logic [63:0] lr;
      if (st && ls < 2) begin
        int m = 1 << w;
        int ua = int'(xa), ub = int'(ya), v, lo, hi;
        if (sg && ua >= m / 2) ua -= m;
        if (sg && ub >= m / 2) ub -= m;
        v  = s ? ua - ub : ua + ub;
        lo = sg ? -(m / 2) : 0;
        hi = sg ? m / 2 - 1 : m - 1;
        if (v > hi) v = hi;
        if (v < lo) v = lo;
        lr = 64'(v);
      end else begin
        lr = s ? xa - ya : xa + ya;
      end
      r |= (lr & mask) << (k * w);
    end
    return r;
  endfunction

  function automatic string tag(input logic [1:0] ls, input logic st, sg);
    if (st && ls >= 2) return "R8";
    if (!st && sg)     return "R9";
    if (!st)           return "R5";
    if (sg)            return "R7";
    return "R6";
  endfunction

  task automatic check(input string req, input logic [63:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] x, y, input logic [1:0] ls,
                     input logic s, st, sg, input string req);
    logic [63:0] exp;
    @(negedge clk);
    a = x; b = y; lane_sel = ls; sub = s; sat_en = st; signed_mode = sg; in_valid = 1'b1;
    exp = model(x, y, ls, s, st, sg);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, result, exp);
    check("R2", {63'd0, out_valid}, 64'd1);
  endtask

  function automatic logic [63:0] pick();
    logic [7:0] pats [6] = '{8'h7F, 8'h80, 8'hFF, 8'h00, 8'h01, 8'hFE};
    case ($urandom % 3)
      0: return {$urandom, $urandom};
      1: return {8{pats[$urandom % 6]}};
      default: return {pats[$urandom % 6], 48'({$urandom, $urandom}), pats[$urandom % 6]};
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1", result, 64'd0);
    check("R1", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;

    run({8{8'hFF}}, {8{8'h01}}, 2'd0, 1'b0, 1'b0, 1'b0, "R4");
    run(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'd1, 1'b0, 1'b0, 1'b0, "R4");
    run(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'd2, 1'b1, 1'b0, 1'b0, "R4");
    run(64'h0000_0000_FFFF_FFFF, 64'd1, 2'd3, 1'b0, 1'b0, 1'b0, "R4");
    run({8{8'hF0}}, {8{8'h20}}, 2'd0, 1'b0, 1'b1, 1'b0, "R6");
    run({8{8'h10}}, {8{8'h20}}, 2'd0, 1'b1, 1'b1, 1'b0, "R6");
    run({4{16'h7FF0}}, {4{16'h0100}}, 2'd1, 1'b0, 1'b1, 1'b1, "R7");
    run({4{16'h8010}}, {4{16'h0100}}, 2'd1, 1'b1, 1'b1, 1'b1, "R7");
    run({2{32'h7FFF_FFFF}}, {2{32'd1}}, 2'd2, 1'b0, 1'b1, 1'b1, "R8");
    run({8{8'h7F}}, {8{8'h01}}, 2'd0, 1'b0, 1'b0, 1'b1, "R9");

    for (int m = 0; m < 32; m++) begin
      logic [7:0] cs [4] = '{8'h7F, 8'h80, 8'hFF, 8'h00};
      for (int p = 0; p < 4; p++)
        for (int q = 0; q < 4; q++)
          run({8{cs[p]}}, {8{cs[q]}}, m[1:0], m[2], m[3], m[4], tag(m[1:0], m[3], m[4]));
    end

    for (int n = 0; n < 2000; n++) begin
      logic [1:0] ls = 2'($urandom);
      logic s = 1'($urandom), st = 1'($urandom), sg = 1'($urandom);
      run(pick(), pick(), ls, s, st, sg, tag(ls, st, sg));
    end

    held = result;
    @(negedge clk);
    a = '1; b = '1; in_valid = 1'b0;
    @(negedge clk);
    check("R3", result, held);
    check("R2", {63'd0, out_valid}, 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule